// File: doc/BRIEF.md
# Pausible-Clock Three-Entry Domain-Crossing FIFO

This block carries data words from a transmitting clock domain to a receiving clock domain through a small circular store. It does not pass pointers through synchronizer flops. Instead it tells each side's local clock generator when to stop.

The sending side has a run output that falls while every slot is occupied. The receiving side has a run output that falls while no slot is occupied. Each side's pausible oscillator holds its clock low while its run output is low. As a result, neither domain ever takes a clock edge while the shared state it depends on is being changed by the other domain.

The sender offers a word with a strobe and a data bus. The receiver takes the oldest word by raising its own strobe. The word then appears on a registered read-data output.

The write slot is tracked by a head pointer and the read slot by a tail pointer. Each pointer has its own incrementer. Each pointer wraps from the last slot back to slot 0 and toggles a phase bit when it wraps. The phase bits let a full store be told apart from an empty one. The oscillators themselves are not part of the block.

Top module: `pgcChannel`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and directly after it is released, `txRun` is 1, `rxRun` is 0 and `rxData` is 0.
- R2: On a rising `txClk` edge with `txReady` high and the store not full, `txData` is stored in the slot at the head, and the head advances by one slot.
- R3: After three writes with no read in between, the store is full and `txRun` is 0.
- R4: A read taken while the store is full sets `txRun` back to 1.
- R5: `rxRun` is 0 while the store is empty. A write into an empty store sets `rxRun` to 1.
- R6: On a rising `rxClk` edge with `rxReady` high and the store not empty, the oldest word is loaded into `rxData` and the tail advances. While `rxReady` is low, `rxData` holds its value.
- R7: A write attempted while the store is full is ignored. The head does not move and the stored words are unchanged.
- R8: A read attempted while the store is empty is ignored. `rxData` and the tail do not change.
- R9: Head and tail count 0, 1, 2 and then return to 0. After two writes and one read, one word is held, and both `txRun` and `rxRun` are 1. Full and empty are never true together.
- R10: When the receiver clock is faster than the transmitter clock, and also when it is slower, every word is delivered exactly once and in the order written, across all pause and resume events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txClk | input | 1 | Transmitter clock, paused externally while `txRun` is low |
| rxClk | input | 1 | Receiver clock, paused externally while `rxRun` is low |
| rstN | input | 1 | Asynchronous active-low reset |
| txReady | input | 1 | Transmitter offers a word this edge |
| txData | input | WIDTH | Offered word |
| txRun | output | 1 | High while a slot is free; the transmitter clock may run |
| rxReady | input | 1 | Receiver takes a word this edge |
| rxData | output | WIDTH | Last word taken, registered |
| rxRun | output | 1 | High while a word is held; the receiver clock may run |

## Verification
On every edge of their own domain, the checker confirms four things. A blocked write leaves the head fixed. A read from an empty store leaves the tail and the read data fixed. An idle receiver leaves the read data fixed. The pointers stay within the three slots, and full and empty are never true together.

Some behaviour is only visible across both domains, and only the bench scenarios can show it. This covers the pause and resume of each clock on the run outputs, and the lossless, duplicate-free ordering under both clock ratios. The bench scenarios also cover the exact word presented after a wrap and the ignored writes made while the transmitter clock is forced to run during a full condition.

// File: rtl/pgc_pkg.sv
`timescale 1ns/1ps
package pgc_pkg;
  // Strobes from control to datapath, one per clock domain.
  typedef struct packed {
    logic wrEn;  // txClk domain: capture txData into the head slot
    logic rdEn;  // rxClk domain: load the tail slot into rxData
  } chanStrobeT;
endpackage

// File: rtl/pgc_ctrl.sv
`timescale 1ns/1ps
module pgcCtrl
  import pgc_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          txClk,
  input  logic          rxClk,
  input  logic          rstN,
  input  logic          txReady,
  input  logic          rxReady,
  output chanStrobeT    strb,
  output logic [IW-1:0] wrIdx,
  output logic [IW-1:0] rdIdx,
  output logic          txRun,
  output logic          rxRun,
  output logic          fullFlag,
  output logic          emptyFlag,
  output logic [IW:0]   headPtr,
  output logic [IW:0]   tailPtr
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  // Pointer = {phase, slot}; the slot wraps at LAST and the phase toggles.
  function automatic logic [IW:0] advance(input logic [IW:0] p);
    if (p[IW-1:0] == LAST) return {~p[IW], {IW{1'b0}}};
    else                   return {p[IW], p[IW-1:0] + 1'b1};
  endfunction

  logic [IW:0] headQ, tailQ;

  assign fullFlag  = (headQ[IW-1:0] == tailQ[IW-1:0]) && (headQ[IW] != tailQ[IW]);
  assign emptyFlag = (headQ == tailQ);

  assign strb.wrEn = txReady && !fullFlag;
  assign strb.rdEn = rxReady && !emptyFlag;

  // Head: sender domain only.
  always_ff @(posedge txClk or negedge rstN) begin
    if (!rstN)          headQ <= '0;
    else if (strb.wrEn) headQ <= advance(headQ);
  end

  // Tail: receiver domain only.
  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN)          tailQ <= '0;
    else if (strb.rdEn) tailQ <= advance(tailQ);
  end

  assign wrIdx   = headQ[IW-1:0];
  assign rdIdx   = tailQ[IW-1:0];
  assign txRun   = !fullFlag;
  assign rxRun   = !emptyFlag;
  assign headPtr = headQ;
  assign tailPtr = tailQ;
endmodule

// File: rtl/pgc_data.sv
`timescale 1ns/1ps
module pgcData
  import pgc_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int WIDTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             txClk,
  input  logic             rxClk,
  input  logic             rstN,
  input  chanStrobeT       strb,
  input  logic [IW-1:0]    wrIdx,
  input  logic [IW-1:0]    rdIdx,
  input  logic [WIDTH-1:0] txData,
  output logic [WIDTH-1:0] rxData
);
  logic [WIDTH-1:0] slot [DEPTH];

  // One register bank per slot, written only from the sender clock.
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge txClk) begin
      if (strb.wrEn && (wrIdx == IW'(g))) slot[g] <= txData;
    end
  end

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN)          rxData <= '0;
    else if (strb.rdEn) rxData <= slot[rdIdx];
  end
endmodule

// File: rtl/pgc_top.sv
`timescale 1ns/1ps
module pgcChannel
  import pgc_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int WIDTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             txClk,
  input  logic             rxClk,
  input  logic             rstN,
  input  logic             txReady,
  input  logic [WIDTH-1:0] txData,
  output logic             txRun,
  input  logic             rxReady,
  output logic [WIDTH-1:0] rxData,
  output logic             rxRun
);
  chanStrobeT    strb;
  logic [IW-1:0] wrIdx, rdIdx;
  logic          fullFlag, emptyFlag;
  logic [IW:0]   headPtr, tailPtr;

  pgcCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .txClk(txClk), .rxClk(rxClk), .rstN(rstN),
    .txReady(txReady), .rxReady(rxReady),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .txRun(txRun), .rxRun(rxRun),
    .fullFlag(fullFlag), .emptyFlag(emptyFlag),
    .headPtr(headPtr), .tailPtr(tailPtr)
  );

  pgcData #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .txClk(txClk), .rxClk(rxClk), .rstN(rstN),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .txData(txData), .rxData(rxData)
  );
endmodule

// File: rtl/pgc_chk.sv
`timescale 1ns/1ps
module pgcChk #(
  parameter int DEPTH = 3,
  parameter int WIDTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             txClk,
  input logic             rxClk,
  input logic             rstN,
  input logic             txReady,
  input logic             rxReady,
  input logic [WIDTH-1:0] rxData,
  input logic             fullFlag,
  input logic             emptyFlag,
  input logic [IW:0]      headPtr,
  input logic [IW:0]      tailPtr
);
  // R2
  head_step_chk: assert property (@(posedge txClk) disable iff (!rstN)
    (txReady && !fullFlag) |=> (headPtr != $past(headPtr)));

  // R7
  full_hold_chk: assert property (@(posedge txClk) disable iff (!rstN)
    fullFlag |=> $stable(headPtr));

  // R8
  empty_hold_chk: assert property (@(posedge rxClk) disable iff (!rstN)
    emptyFlag |=> ($stable(tailPtr) && $stable(rxData)));

  // R6
  idle_rx_chk: assert property (@(posedge rxClk) disable iff (!rstN)
    !rxReady |=> $stable(rxData));

  // R9
  head_range_chk: assert property (@(posedge txClk) disable iff (!rstN)
    int'(headPtr[IW-1:0]) < DEPTH);

  // R9
  tail_range_chk: assert property (@(posedge rxClk) disable iff (!rstN)
    int'(tailPtr[IW-1:0]) < DEPTH);

  // R9
  flag_excl_chk: assert property (@(posedge rxClk) disable iff (!rstN)
    !(fullFlag && emptyFlag));
endmodule

bind pgcChannel pgcChk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .txClk(txClk), .rxClk(rxClk), .rstN(rstN),
  .txReady(txReady), .rxReady(rxReady), .rxData(rxData),
  .fullFlag(fullFlag), .emptyFlag(emptyFlag),
  .headPtr(headPtr), .tailPtr(tailPtr)
);

// File: tb/pgcChannel_tb.sv
`timescale 1ns/1ps
module pgcChannel_tb;
  localparam int WIDTH = 8;

  logic txClk = 0, rxClk = 0, rstN = 0;
  logic txReady = 0, rxReady = 0;
  logic [WIDTH-1:0] txData = '0;
  logic [WIDTH-1:0] rxData;
  logic txRun, rxRun;

  int checks = 0, errors = 0;
  bit txForce = 0, rxForce = 0, monOn = 0;
  real rxHalf = 1.7;
  logic [WIDTH-1:0] sb[$];
  int popped = 0;

  pgcChannel #(.DEPTH(3), .WIDTH(WIDTH)) u_dut (
    .txClk(txClk), .rxClk(rxClk), .rstN(rstN),
    .txReady(txReady), .txData(txData), .txRun(txRun),
    .rxReady(rxReady), .rxData(rxData), .rxRun(rxRun)
  );

  // Pausible oscillators: a rising edge only when run is high (or forced).
  initial forever begin
    #2.5; if (txRun || txForce) txClk = 1;
    #2.5; txClk = 0;
  end
  initial begin
    #0.3;
    forever begin
      #(rxHalf); if (rxRun || rxForce) rxClk = 1;
      #(rxHalf); rxClk = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: every permitted tx edge with txReady high is a write.
  task automatic sendWord(input logic [WIDTH-1:0] w, input bit track);
    txData = w; txReady = 1;
    @(posedge txClk);
    if (track) sb.push_back(w);
    #0.2; txReady = 0;
  endtask

  task automatic takeWord();
    rxReady = 1;
    @(posedge rxClk);
    #0.2; rxReady = 0;
  endtask

  // Monitor: compares each delivered word with the scoreboard head.
  initial forever begin
    @(posedge rxClk);
    if (monOn && rxReady) begin
      #0.2;
      if (sb.size() == 0) chk("R10 unexpected word", 32'(rxData), 32'hFFFF_FFFF);
      else begin
        chk("R10 order", 32'(rxData), 32'(sb.pop_front()));
        popped++;
      end
    end
  end

  // Watchdog
  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    #7;
    // R1 during reset
    chk("R1 txRun", 32'(txRun), 1); chk("R1 rxRun", 32'(rxRun), 0);
    chk("R1 rxData", 32'(rxData), 0);
    rstN = 1; #3;
    chk("R1 after release", {30'd0, txRun, rxRun}, 32'b10);

    // R8: force the receiver clock while empty
    rxForce = 1; rxReady = 1;
    repeat (4) @(posedge rxClk);
    #0.2; rxForce = 0; rxReady = 0;
    chk("R8 rxData", 32'(rxData), 0); chk("R8 rxRun", 32'(rxRun), 0);

    // R3 / R5: three writes, no reads
    sendWord(8'hA1, 0);
    chk("R5 wake", 32'(rxRun), 1);
    sendWord(8'hB2, 0);
    chk("R2 not full yet", 32'(txRun), 1);
    sendWord(8'hC3, 0);
    chk("R3 full", 32'(txRun), 0);

    // R7: forced tx clock while full
    txForce = 1; txData = 8'hEE; txReady = 1;
    repeat (3) @(posedge txClk);
    #0.2; txReady = 0; txForce = 0;
    chk("R7 still full", 32'(txRun), 0);

    // R6: idle receiver leaves rxData
    repeat (3) @(posedge rxClk);
    #0.2; chk("R6 hold", 32'(rxData), 0);

    takeWord();
    chk("R6 oldest", 32'(rxData), 8'hA1);
    #0.5; chk("R4 resume", 32'(txRun), 1);
    takeWord(); chk("R2 second", 32'(rxData), 8'hB2);
    takeWord(); chk("R7 third intact", 32'(rxData), 8'hC3);
    #0.5; chk("R5 empty", 32'(rxRun), 0);

    // R9: wrapped pointers, two writes then one read
    sendWord(8'hD4, 0); sendWord(8'h5E, 0);
    takeWord(); chk("R9 wrap word", 32'(rxData), 8'hD4);
    #0.5; chk("R9 flags", {30'd0, txRun, rxRun}, 32'b11);
    takeWord(); chk("R9 next", 32'(rxData), 8'h5E);

    // R10: streaming, receiver faster, then slower
    monOn = 1; rxReady = 1;
    for (int ph = 0; ph < 2; ph++) begin
      rxHalf = (ph == 0) ? 1.7 : 6.3;
      for (int i = 0; i < 150; i++) begin
        sendWord(WIDTH'(i * 7 + ph * 3 + 1), 1);
        repeat ($urandom_range(0, 2)) @(posedge txClk);
      end
      repeat (50) #20 if (sb.size() == 0) break;
      chk("R10 drained", 32'(sb.size()), 0);
    end
    chk("R10 count", 32'(popped), 300);
    finish();
  end
endmodule